// File: doc/BRIEF.md
# Multicycle Teaching Processor Core

This block is a small processor that executes one instruction at a time through a fixed ladder of phases. The ladder runs: fetch a 32-bit word from the instruction port, advance the instruction pointer, split the word into its fields, read the source registers, execute, and write the result back. A data port serves load and store. A register file of sixteen 32-bit general-purpose registers holds operands and results. The instruction set covers three groups:

- data movement: load and store to an absolute 16-bit address;
- data transformation: NOT, AND, OR, XOR, ADD, left and right logical shifts, and arithmetic right shift;
- sequence control: unconditional jump, jump when a register is nonzero, and halt.

Every instruction occupies one 32-bit word and comes in one of two layouts. The register layout carries an op code and three 4-bit register numbers, and its low twelve bits are padding. The memory layout carries an op code, one register number, an unused nibble and a 16-bit address or jump target. A status word keeps zero, carry and overflow flags from the last ADD. Two outputs report the halted state and an illegal op code.

The core is meant to sit against two simple synchronous memories. Instruction reads return data one clock after the address is presented. Data reads are strobed once and complete when the memory raises its valid signal. This lets the core tolerate any read latency of one cycle or more.

Top module: `mc_core`

## Requirements
- R1: While reset is held, and right after it, imem_addr is 0, halted, illegal, dmem_re, dmem_we and all three flags are 0, and every register reads as zero.
- R2: Register layout: bits 31:24 op code, 23:20 destination, 19:16 first source, 15:12 second source. Bits 11:0 are padding and have no effect on the result. Memory layout: bits 31:24 op code, 23:20 register, 19:16 unused, 15:0 address or target.
- R3: An instruction other than a load takes exactly six clock cycles. A halt reaches the halted state in its fifth cycle. The instruction pointer counts words and moves past each fetched word.
- R4: Op codes 0x10 NOT (first source only), 0x11 AND, 0x12 OR and 0x13 XOR write the bitwise result to the destination.
- R5: Op code 0x14 ADD writes the 32-bit sum and sets zero (sum is 0), carry (carry out of bit 31) and overflow (signed overflow). No other instruction changes the flags.
- R6: Op code 0x15 shifts left, 0x16 shifts right filling with zeros, and 0x17 shifts right copying bit 31. The shift amount is the low 5 bits of the register named by the second source field.
- R7: Op code 0x01 loads the data word at the 16-bit address into the register field. dmem_re is a one-cycle strobe, and the core waits until dmem_rvalid. A load takes 6 plus the read latency in cycles.
- R8: Op code 0x02 writes the register field's value to the 16-bit address with a single one-cycle dmem_we pulse.
- R9: Op code 0x20 always continues execution at the 16-bit target.
- R10: Op code 0x21 continues at the 16-bit target when the named register is nonzero, and with the next word otherwise.
- R11: Op code 0xFF sets halted. After that the instruction pointer holds, no memory strobe occurs, and the state stays until reset.
- R12: Any op code not listed sets illegal and halted at the end of the decode phase, in the third cycle of the instruction, and nothing after it executes.
- R13: dmem_re and dmem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 16 | Word address of the instruction to fetch |
| imem_rdata | input | 32 | Instruction word, valid one cycle after the address |
| dmem_addr | output | 16 | Data word address |
| dmem_re | output | 1 | One-cycle read strobe |
| dmem_we | output | 1 | One-cycle write strobe |
| dmem_wdata | output | 32 | Data to write |
| dmem_rdata | input | 32 | Read data, sampled while dmem_rvalid is high |
| dmem_rvalid | input | 1 | Read data valid |
| halted | output | 1 | Core has stopped fetching |
| illegal | output | 1 | Stop was caused by an unknown op code |
| flag_z | output | 1 | Zero flag from the last ADD |
| flag_c | output | 1 | Carry flag from the last ADD |
| flag_v | output | 1 | Overflow flag from the last ADD |

## Verification
All eight transformation op codes run against every pair from a set of eight operands. The operands are zero, one, 31, 33, the sign bit alone, all ones, the largest positive value and a mixed pattern. Between them they separate zero fill from sign fill, show that only the low five bits of the amount count (33 behaves as 1), and exercise carry, signed overflow and the zero flag. Alternate runs set the padding bits to all ones, to show that padding is ignored. Jump runs take both the nonzero and the zero path, including a register whose only set bit is bit 31. Load runs use read latencies of one and three cycles, which separates waiting for the valid signal from a fixed wait. Cycle counts to the halted state pin down the phase sequence, and op codes adjacent to the legal ranges check the illegal path.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;

   localparam int INSN_W = 32;
   localparam int OPC_LSB = 24;
   localparam int FD_LSB  = 20;
   localparam int FA_LSB  = 16;
   localparam int FB_LSB  = 12;
   localparam int IMM_W   = 16;

   localparam logic [7:0] OPC_LOAD  = 8'h01;
   localparam logic [7:0] OPC_STORE = 8'h02;
   localparam logic [4:0] OPC_ALU_HI = 5'b00010;
   localparam logic [7:0] OPC_JUMP  = 8'h20;
   localparam logic [7:0] OPC_JUMPC = 8'h21;
   localparam logic [7:0] OPC_STOP  = 8'hFF;

   typedef enum logic [2:0] {
      PH_FETCH, PH_STEP, PH_DECODE, PH_OPERAND, PH_EXEC, PH_WBACK, PH_STOP
   } phase_e;

   typedef enum logic [2:0] {
      K_ALU, K_LOAD, K_STORE, K_JUMP, K_JUMPC, K_STOP, K_BAD
   } kind_e;

   typedef enum logic [2:0] {
      F_NOT, F_AND, F_OR, F_XOR, F_ADD, F_SHL, F_SHR, F_SAR
   } fn_e;

   typedef struct packed {
      kind_e kind;
      fn_e   fn;
   } ctl_t;

endpackage

// File: rtl/mc_decode.sv
module mc_decode
   import mc_core_pkg::*;
(
   input  logic [7:0] opc,
   output ctl_t       ctl
);

   always_comb begin
      ctl.fn   = fn_e'(opc[2:0]);
      ctl.kind = K_BAD;
      case (opc)
         OPC_LOAD:  ctl.kind = K_LOAD;
         OPC_STORE: ctl.kind = K_STORE;
         OPC_JUMP:  ctl.kind = K_JUMP;
         OPC_JUMPC: ctl.kind = K_JUMPC;
         OPC_STOP:  ctl.kind = K_STOP;
         default: begin
            if (opc[7:3] == OPC_ALU_HI) ctl.kind = K_ALU;
         end
      endcase
   end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
   import mc_core_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit LOG_SHIFT = 1'b1
)(
   input  fn_e               fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y,
   output logic              co,
   output logic              ov
);

   localparam int SH_W = $clog2(DATA_W);
   localparam int MSB  = DATA_W - 1;

   logic [SH_W-1:0]   amt;
   logic              fill;
   logic [DATA_W-1:0] shl;
   logic [DATA_W-1:0] shr;
   logic [DATA_W:0]   sum;

   assign amt  = b[SH_W-1:0];
   assign fill = (fn == F_SAR) && a[MSB];
   assign sum  = {1'b0, a} + {1'b0, b};

   generate
      if (LOG_SHIFT) begin : g_log
         logic [DATA_W-1:0] lst [SH_W+1];
         logic [DATA_W-1:0] rsh [SH_W+1];
         assign lst[0] = a;
         assign rsh[0] = a;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int S = 1 << k;
            assign lst[k+1] = amt[k] ? {lst[k][DATA_W-1-S:0], {S{1'b0}}} : lst[k];
            assign rsh[k+1] = amt[k] ? {{S{fill}}, rsh[k][DATA_W-1:S]} : rsh[k];
         end
         assign shl = lst[SH_W];
         assign shr = rsh[SH_W];
      end else begin : g_op
         logic signed [DATA_W-1:0] sa;
         logic        [DATA_W-1:0] ar;
         logic        [DATA_W-1:0] lr;
         assign sa  = $signed(a);
         assign ar  = sa >>> amt;
         assign lr  = a >> amt;
         assign shl = a << amt;
         assign shr = fill ? ar : lr;
      end
   endgenerate

   always_comb begin
      case (fn)
         F_NOT:   y = ~a;
         F_AND:   y = a & b;
         F_OR:    y = a | b;
         F_XOR:   y = a ^ b;
         F_ADD:   y = sum[MSB:0];
         F_SHL:   y = shl;
         default: y = shr;
      endcase
   end

   assign co = sum[DATA_W];
   assign ov = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
   parameter int DATA_W  = 32,
   parameter int REG_CNT = 16,
   localparam int IDX_W  = $clog2(REG_CNT)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra_a,
   input  logic [IDX_W-1:0]  ra_b,
   input  logic [IDX_W-1:0]  ra_s,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic [DATA_W-1:0] rd_s
);

   logic [DATA_W-1:0] regs [REG_CNT];

   generate
      for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               q <= '0;
            else if (we && (waddr == IDX_W'(g)))      q <= wdata;
         end
         assign regs[g] = q;
      end
   endgenerate

   assign rd_a = regs[ra_a];
   assign rd_b = regs[ra_b];
   assign rd_s = regs[ra_s];

endmodule

// File: rtl/mc_core.sv
module mc_core
   import mc_core_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_CNT   = 16,
   parameter int IP_W      = 16,
   parameter bit LOG_SHIFT = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic [IP_W-1:0]   imem_addr,
   input  logic [INSN_W-1:0] imem_rdata,
   output logic [IMM_W-1:0]  dmem_addr,
   output logic              dmem_re,
   output logic              dmem_we,
   output logic [DATA_W-1:0] dmem_wdata,
   input  logic [DATA_W-1:0] dmem_rdata,
   input  logic              dmem_rvalid,
   output logic              halted,
   output logic              illegal,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v
);

   localparam int IDX_W = $clog2(REG_CNT);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_w
         $error("mc_core: DATA_W must be a power of two of at least 8");
      end
      if (REG_CNT < 2 || REG_CNT > 16 || (REG_CNT & (REG_CNT - 1)) != 0) begin : g_chk_r
         $error("mc_core: REG_CNT must be a power of two from 2 to 16");
      end
      if (IP_W < 1 || IP_W > IMM_W) begin : g_chk_ip
         $error("mc_core: IP_W must fit the 16-bit target field");
      end
   endgenerate

   phase_e             phase_q;
   logic [IP_W-1:0]    pc_q;
   logic [INSN_W-1:0]  ir_q;
   ctl_t               ctl_q;
   ctl_t               dec_ctl;
   logic [IDX_W-1:0]   fd_q, fa_q, fb_q;
   logic [IMM_W-1:0]   imm_q;
   logic [DATA_W-1:0]  a_q, b_q, s_q, res_q;
   logic [DATA_W-1:0]  rd_a, rd_b, rd_s;
   logic [DATA_W-1:0]  alu_y;
   logic               alu_co, alu_ov;
   logic               wait_q, halted_q, illegal_q;
   logic               zf_q, cf_q, vf_q;
   logic               rf_we;

   mc_decode u_dec (
      .opc (ir_q[INSN_W-1:OPC_LSB]),
      .ctl (dec_ctl)
   );

   mc_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (fd_q),
      .wdata (res_q),
      .ra_a  (fa_q),
      .ra_b  (fb_q),
      .ra_s  (fd_q),
      .rd_a  (rd_a),
      .rd_b  (rd_b),
      .rd_s  (rd_s)
   );

   mc_alu #(.DATA_W(DATA_W), .LOG_SHIFT(LOG_SHIFT)) u_alu (
      .fn (ctl_q.fn),
      .a  (a_q),
      .b  (b_q),
      .y  (alu_y),
      .co (alu_co),
      .ov (alu_ov)
   );

   assign rf_we = (phase_q == PH_WBACK) &&
                  ((ctl_q.kind == K_ALU) || (ctl_q.kind == K_LOAD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_FETCH;
         pc_q      <= '0;
         ir_q      <= '0;
         ctl_q     <= '{kind: K_STOP, fn: F_NOT};
         fd_q      <= '0;
         fa_q      <= '0;
         fb_q      <= '0;
         imm_q     <= '0;
         a_q       <= '0;
         b_q       <= '0;
         s_q       <= '0;
         res_q     <= '0;
         wait_q    <= 1'b0;
         halted_q  <= 1'b0;
         illegal_q <= 1'b0;
         zf_q      <= 1'b0;
         cf_q      <= 1'b0;
         vf_q      <= 1'b0;
      end else begin
         case (phase_q)
            PH_FETCH: phase_q <= PH_STEP;
            PH_STEP: begin
               ir_q    <= imem_rdata;
               pc_q    <= pc_q + 1'b1;
               phase_q <= PH_DECODE;
            end
            PH_DECODE: begin
               ctl_q <= dec_ctl;
               fd_q  <= ir_q[FD_LSB +: IDX_W];
               fa_q  <= ir_q[FA_LSB +: IDX_W];
               fb_q  <= ir_q[FB_LSB +: IDX_W];
               imm_q <= ir_q[IMM_W-1:0];
               if (dec_ctl.kind == K_BAD) begin
                  illegal_q <= 1'b1;
                  halted_q  <= 1'b1;
                  phase_q   <= PH_STOP;
               end else begin
                  phase_q <= PH_OPERAND;
               end
            end
            PH_OPERAND: begin
               a_q     <= rd_a;
               b_q     <= rd_b;
               s_q     <= rd_s;
               phase_q <= PH_EXEC;
            end
            PH_EXEC: begin
               case (ctl_q.kind)
                  K_ALU: begin
                     res_q <= alu_y;
                     if (ctl_q.fn == F_ADD) begin
                        zf_q <= (alu_y == '0);
                        cf_q <= alu_co;
                        vf_q <= alu_ov;
                     end
                     phase_q <= PH_WBACK;
                  end
                  K_LOAD: begin
                     if (!wait_q) begin
                        wait_q <= 1'b1;
                     end else if (dmem_rvalid) begin
                        res_q   <= dmem_rdata;
                        wait_q  <= 1'b0;
                        phase_q <= PH_WBACK;
                     end
                  end
                  K_STORE: phase_q <= PH_WBACK;
                  K_JUMP: begin
                     pc_q    <= imm_q[IP_W-1:0];
                     phase_q <= PH_WBACK;
                  end
                  K_JUMPC: begin
                     if (s_q != '0) pc_q <= imm_q[IP_W-1:0];
                     phase_q <= PH_WBACK;
                  end
                  default: begin
                     halted_q <= 1'b1;
                     phase_q  <= PH_STOP;
                  end
               endcase
            end
            PH_WBACK: phase_q <= PH_FETCH;
            default:  phase_q <= PH_STOP;
         endcase
      end
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = imm_q;
   assign dmem_wdata = s_q;
   assign dmem_re    = (phase_q == PH_EXEC) && (ctl_q.kind == K_LOAD) && !wait_q;
   assign dmem_we    = (phase_q == PH_EXEC) && (ctl_q.kind == K_STORE);
   assign halted     = halted_q;
   assign illegal    = illegal_q;
   assign flag_z     = zf_q;
   assign flag_c     = cf_q;
   assign flag_v     = vf_q;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
   parameter int IP_W = 16
)(
   input logic            clk,
   input logic            rst_n,
   input logic [IP_W-1:0] imem_addr,
   input logic            dmem_re,
   input logic            dmem_we,
   input logic            halted,
   input logic            illegal
);

   p_stop_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_stop_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!dmem_re && !dmem_we));

   p_stop_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr));

   p_bad_stops_r12: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> halted);

   p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_re && dmem_we));

   p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_re |=> !dmem_re);

   p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |=> !dmem_we);

endmodule

bind mc_core mc_core_chk #(.IP_W(IP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imem_addr (imem_addr),
   .dmem_re   (dmem_re),
   .dmem_we   (dmem_we),
   .halted    (halted),
   .illegal   (illegal)
);

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;

   localparam logic [7:0] T_LD = 8'h01, T_ST = 8'h02, T_BR = 8'h20,
                          T_BRC = 8'h21, T_HLT = 8'hFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] imem_addr;
   logic [31:0] imem_rdata = '0;
   logic [15:0] dmem_addr;
   logic        dmem_re, dmem_we;
   logic [31:0] dmem_wdata;
   logic [31:0] dmem_rdata = '0;
   logic        dmem_rvalid = 1'b0;
   logic        halted, illegal, flag_z, flag_c, flag_v;

   logic [31:0] imem [256];
   logic [31:0] dmem [256];
   int          lat_cfg = 1;
   logic        pend = 1'b0;
   int          cnt = 0;
   logic [7:0]  paddr = '0;
   int          we_cnt = 0, re_cnt = 0, both_cnt = 0;
   int          total = 0, bad = 0, tick = 0;
   int          cyc;
   logic [31:0] vals [8];

   always #10 clk = ~clk;

   mc_core u_dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
      .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_rvalid(dmem_rvalid),
      .halted(halted), .illegal(illegal), .flag_z(flag_z), .flag_c(flag_c),
      .flag_v(flag_v)
   );

   always @(posedge clk) imem_rdata <= imem[imem_addr[7:0]];

   always @(posedge clk) begin
      dmem_rvalid <= 1'b0;
      if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
      if (dmem_re) begin
         if (lat_cfg <= 1) begin
            dmem_rvalid <= 1'b1;
            dmem_rdata  <= dmem[dmem_addr[7:0]];
         end else begin
            pend  <= 1'b1;
            cnt   <= lat_cfg - 1;
            paddr <= dmem_addr[7:0];
         end
      end else if (pend) begin
         if (cnt == 1) begin
            dmem_rvalid <= 1'b1;
            dmem_rdata  <= dmem[paddr];
            pend        <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && dmem_we) we_cnt++;
      if (rst_n && dmem_re) re_cnt++;
      if (rst_n && dmem_we && dmem_re) both_cnt++;
   end

   always @(posedge clk) begin
      tick++;
      if (tick > 190000) begin
         bad++;
         $display("FAIL watchdog act=%0d exp=<190000", tick);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input logic [7:0] op, input logic [3:0] d,
                                         input logic [3:0] s1, input logic [3:0] s2,
                                         input logic [11:0] pad);
      return {op, d, s1, s2, pad};
   endfunction

   function automatic logic [31:0] enc_m(input logic [7:0] op, input logic [3:0] r,
                                         input logic [15:0] imm);
      return {op, r, 4'h0, imm};
   endfunction

   function automatic logic [31:0] exp_alu(input int o, input logic [31:0] a,
                                           input logic [31:0] b);
      logic signed [31:0] sa;
      logic [31:0] r;
      int sh;
      sh = int'(b[4:0]);
      sa = a;
      case (o)
         0: r = ~a;
         1: r = a & b;
         2: r = a | b;
         3: r = a ^ b;
         4: r = a + b;
         5: r = a << sh;
         6: r = a >> sh;
         default: r = sa >>> sh;
      endcase
      return r;
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) begin
         imem[i] = {T_HLT, 24'h0};
         dmem[i] = '0;
      end
   endtask

   task automatic run(input int lat, output int n);
      lat_cfg = lat;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      we_cnt = 0;
      re_cnt = 0;
      rst_n = 1'b1;
      n = 0;
      while (!halted && n < 3000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      logic [31:0] a, b, ef;
      logic [11:0] pad;
      string rq;
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
      vals[2] = 32'h0000_001F; vals[3] = 32'h0000_0021;
      vals[4] = 32'h8000_0000; vals[5] = 32'hFFFF_FFFF;
      vals[6] = 32'h7FFF_FFFF; vals[7] = 32'h1234_5678;
      clear_mem();

      // R1: reset state at the ports
      repeat (3) @(negedge clk);
      chk("R1 imem_addr", 32'(imem_addr), 32'h0);
      chk("R1 status", {28'h0, halted, illegal, dmem_re, dmem_we}, 32'h0);
      chk("R1 flags", {29'h0, flag_z, flag_c, flag_v}, 32'h0);
      // R1: registers start at zero
      imem[0] = enc_m(T_ST, 4'd5, 16'h0040);
      dmem[8'h40] = 32'hDEAD_BEEF;
      run(1, cyc);
      chk("R1 reg zero", dmem[8'h40], 32'h0);
      chk("R1 no illegal", 32'(illegal), 32'h0);

      // R4 R5 R6 sweep; R2 padding alternates between zero and all ones
      for (int o = 0; o < 8; o++) begin
         for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
               clear_mem();
               a = vals[i];
               b = vals[j];
               pad = ((i + j) % 2 == 1) ? 12'hFFF : 12'h000;
               imem[0] = enc_m(T_LD, 4'd1, 16'h0010);
               imem[1] = enc_m(T_LD, 4'd2, 16'h0011);
               imem[2] = enc_r(8'h10 + 8'(o), 4'd3, 4'd1, 4'd2, pad);
               imem[3] = enc_m(T_ST, 4'd3, 16'h0020);
               dmem[8'h10] = a;
               dmem[8'h11] = b;
               run(1, cyc);
               rq = (o < 4) ? "R4 R2 logic" : (o == 4) ? "R5 R2 add" : "R6 R2 shift";
               chk(rq, dmem[8'h20], exp_alu(o, a, b));
               if (o == 4) begin
                  ef = {29'h0, (a + b) == 32'h0, ({1'b0, a} + {1'b0, b}) > 33'hFFFF_FFFF,
                        (a[31] == b[31]) && ((a + b) >> 31 != {31'h0, a[31]})};
                  chk("R5 flags", {29'h0, flag_z, flag_c, flag_v}, ef);
               end else begin
                  chk("R5 flags untouched", {29'h0, flag_z, flag_c, flag_v}, 32'h0);
               end
            end
         end
      end

      // R5: flags survive a later non-ADD instruction
      clear_mem();
      imem[0] = enc_m(T_LD, 4'd1, 16'h0010);
      imem[1] = enc_m(T_LD, 4'd2, 16'h0011);
      imem[2] = enc_r(8'h14, 4'd3, 4'd1, 4'd2, 12'h0);
      imem[3] = enc_r(8'h11, 4'd4, 4'd1, 4'd2, 12'h0);
      imem[4] = enc_r(8'h17, 4'd5, 4'd1, 4'd2, 12'h0);
      dmem[8'h10] = 32'hFFFF_FFFF;
      dmem[8'h11] = 32'h0000_0001;
      run(1, cyc);
      chk("R5 flags kept", {29'h0, flag_z, flag_c, flag_v}, 32'h6);

      // R3: three six-cycle instructions then a halt in its fifth cycle
      clear_mem();
      for (int k = 0; k < 3; k++) imem[k] = enc_r(8'h13, 4'd0, 4'd0, 4'd0, 12'h0);
      run(1, cyc);
      chk("R3 cycles", 32'(cyc), 32'd23);
      chk("R3 pointer", 32'(imem_addr), 32'd4);
      // R11: stays stopped
      repeat (20) @(negedge clk);
      chk("R11 pointer held", 32'(imem_addr), 32'd4);
      chk("R11 still halted", 32'(halted), 32'h1);
      chk("R11 no strobes", 32'(we_cnt + re_cnt), 32'h0);

      // R7 R8: load latency 1 and 3
      for (int l = 1; l <= 3; l += 2) begin
         clear_mem();
         imem[0] = enc_m(T_LD, 4'd7, 16'h0010);
         imem[1] = enc_m(T_ST, 4'd7, 16'h0020);
         dmem[8'h10] = 32'hA5A5_0F0F + 32'(l);
         run(l, cyc);
         chk("R7 load cycles", 32'(cyc), 32'(17 + l));
         chk("R7 load data", dmem[8'h20], 32'hA5A5_0F0F + 32'(l));
         chk("R7 one read strobe", 32'(re_cnt), 32'h1);
         chk("R8 one write strobe", 32'(we_cnt), 32'h1);
      end

      // R9: unconditional jump skips words 2 and 3
      clear_mem();
      imem[0] = enc_m(T_LD, 4'd1, 16'h0010);
      imem[1] = enc_m(T_BR, 4'd0, 16'h0004);
      imem[2] = enc_m(T_ST, 4'd1, 16'h0030);
      imem[4] = enc_m(T_ST, 4'd1, 16'h0031);
      dmem[8'h10] = 32'h0000_0777;
      dmem[8'h30] = 32'hDEAD_BEEF;
      run(1, cyc);
      chk("R9 skipped", dmem[8'h30], 32'hDEAD_BEEF);
      chk("R9 target", dmem[8'h31], 32'h0000_0777);
      chk("R9 pointer", 32'(imem_addr), 32'd6);

      // R10: conditional jump, zero and nonzero (incl. only bit 31 set)
      for (int c = 0; c < 3; c++) begin
         clear_mem();
         a = (c == 0) ? 32'h0 : (c == 1) ? 32'h0000_0100 : 32'h8000_0000;
         imem[0] = enc_m(T_LD, 4'd1, 16'h0010);
         imem[1] = enc_m(T_BRC, 4'd1, 16'h0004);
         imem[2] = enc_m(T_ST, 4'd1, 16'h0030);
         imem[4] = enc_m(T_ST, 4'd1, 16'h0031);
         dmem[8'h10] = a;
         dmem[8'h30] = 32'hDEAD_BEEF;
         dmem[8'h31] = 32'hDEAD_BEEF;
         run(1, cyc);
         chk("R10 fallthrough word", dmem[8'h30], (c == 0) ? 32'h0 : 32'hDEAD_BEEF);
         chk("R10 target word", dmem[8'h31], (c == 0) ? 32'hDEAD_BEEF : a);
      end

      // R12: unknown op codes next to legal ranges
      for (int u = 0; u < 3; u++) begin
         clear_mem();
         imem[0] = {(u == 0) ? 8'h00 : (u == 1) ? 8'h18 : 8'h33, 24'h0};
         imem[1] = enc_m(T_ST, 4'd0, 16'h0030);
         dmem[8'h30] = 32'hDEAD_BEEF;
         run(1, cyc);
         chk("R12 illegal", {30'h0, illegal, halted}, 32'h3);
         chk("R12 cycles", 32'(cyc), 32'd3);
         repeat (10) @(negedge clk);
         chk("R12 nothing after", dmem[8'h30], 32'hDEAD_BEEF);
      end

      // R13: strobes never overlapped across the whole run
      chk("R13 exclusive strobes", 32'(both_cnt), 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule